// File: doc/BRIEF.md
# Parallel Display Bus Transaction Sequencer

This block drives one transaction at a time onto an 8- or 16-bit parallel display bus. A transaction has up to three phases, always in the order command, dummy, data. Any phase can be left out, and each enabled phase has its own cycle count. A pixel-clock tick input paces the bus: each tick starts at most one bus cycle. A data/command line is held at a chosen idle level. Each phase can drive either that level or its inverse.

Outgoing data arrives as 16-bit words on a valid/ready stream. In 8-bit mode each word gives two bus cycles. Optional byte swapping and bit reversal reshape what appears on the pins. A stream mode lets the data phase run for as long as words keep arriving.

Configuration is captured when the run request rises. Dropping the request aborts the transaction, and a soft-reset pulse aborts it and wipes the interrupt status. Two sticky interrupt sources each have an enable bit and a write-one-to-clear bit: transaction done and an external vertical-sync end event.

Top module: `pbus_seq`

## Requirements
- R1: Enabled phases run in the order command, dummy, data, and disabled phases are skipped. Each tick while busy emits at most one bus cycle. Phase codes are idle=0, command=1, dummy=2, data=3.
- R2: The command phase lasts 1 cycle, or 2 when `cfg_cmd_two` is set. The first cycle sends `cfg_cmd_word[15:0]` and the second sends `cfg_cmd_word[31:16]`. In 8-bit mode only the low byte of each half appears, on `bus_data[7:0]`, and `bus_data[15:8]` is 0.
- R3: The dummy phase lasts `cfg_dummy_m1`+1 cycles and drives 0 on the bus. Outside stream mode, the data phase lasts `cfg_data_m1`+1 cycles.
- R4: With `cfg_stream` set, the data phase ignores `cfg_data_m1`. It continues while words are offered and ends at the first tick that needs a new word when `in_valid` is low.
- R5: While not busy, `bus_dc` equals the latched idle level. In a phase, `bus_dc` is the idle level XOR that phase's invert bit, and it changes with the phase's first cycle.
- R6: In 8-bit mode each input word yields two data cycles, low byte first. With `cfg_swap` the high byte goes first, so bytes B0 B1 B2 B3 leave as B1 B0 B3 B2.
- R7: In 16-bit mode each data cycle consumes one word. With `cfg_swap` its two bytes are exchanged.
- R8: With `cfg_bitrev` the active lanes are mirrored: bit i moves to bit 7-i in 8-bit mode and to bit 15-i in 16-bit mode. This applies to command and data cycles alike.
- R9: All `cfg_*` inputs are captured on the rising edge of `go` while idle. Later changes have no effect on the running transaction.
- R10: Lowering `go` while busy returns the block to idle at the next clock edge, with bus 0 and the DC line at idle. The done status is not set.
- R11: Outside stream mode, a data cycle that needs a word waits while `in_valid` is low, and all outputs hold. `in_ready` is high only in a tick cycle that consumes a word.
- R12: Status bit 0 is transaction done and bit 1 is the vsync-end event. Each bit is set by its event and stays set until a 1 is written to the matching `irq_clr` bit; a set in the same cycle wins over a clear. `irq` is the OR of status AND enable.
- R13: A `soft_rst` pulse aborts any transaction and clears both status bits.
- R14: The tick after the last cycle ends the transaction. The bus returns to 0, `bus_dc` to idle and `busy` to 0, and the done status is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Run request; rising edge latches config and starts, low aborts |
| soft_rst | input | 1 | Abort pulse that also clears status |
| tick | input | 1 | Pixel-clock tick, one bus cycle per tick |
| cfg_cmd_en | input | 1 | Command phase enable |
| cfg_cmd_two | input | 1 | Two-cycle command |
| cfg_dummy_en | input | 1 | Dummy phase enable |
| cfg_dummy_m1 | input | DUMMY_CW | Dummy cycles minus one |
| cfg_data_en | input | 1 | Data phase enable |
| cfg_data_m1 | input | DATA_CW | Data cycles minus one |
| cfg_stream | input | 1 | Data phase runs while words are offered |
| cfg_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_swap | input | 1 | Byte-order swap |
| cfg_bitrev | input | 1 | Bit-order reversal on active lanes |
| cfg_dc_idle | input | 1 | DC idle level |
| cfg_dc_cmd_inv | input | 1 | Invert DC in command phase |
| cfg_dc_dummy_inv | input | 1 | Invert DC in dummy phase |
| cfg_dc_data_inv | input | 1 | Invert DC in data phase |
| cfg_cmd_word | input | 32 | Command value |
| in_data | input | 16 | Outgoing data word |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Data word consumed this cycle |
| bus_data | output | 16 | Parallel bus data |
| bus_dc | output | 1 | Data/command line |
| busy | output | 1 | Transaction in progress |
| vsync_evt | input | 1 | Vertical-sync end event pulse |
| irq_en | input | 2 | Interrupt enables |
| irq_clr | input | 2 | Write-one-to-clear strobes |
| irq_status | output | 2 | Raw sticky status |
| irq | output | 1 | Combined interrupt |

## Verification
The checker assumes the stream handshake is well-behaved: `in_valid` does not depend on `in_ready`. It also assumes `go` only rises after the previous transaction has ended or been aborted. The hold property assumes that between ticks nothing but the tick moves the sequencer, so it does not cover cycles that carry `soft_rst` or a low `go`. The bench drives each tick as a single-cycle pulse and feeds words from a fixed list, so the offer is decided before the cycle. It raises `go` only from idle, and it lowers `go` or pulses `soft_rst` only to test abort.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CMD   = 2'd1,
    PH_DUMMY = 2'd2,
    PH_DATA  = 2'd3
  } phase_e;

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  // first enabled phase strictly after cur, or idle when none remains
  function automatic phase_e next_phase(input phase_e cur, input logic c_en,
                                        input logic d_en, input logic x_en);
    phase_e r;
    r = PH_IDLE;
    if (cur == PH_IDLE && c_en) r = PH_CMD;
    else if ((cur == PH_IDLE || cur == PH_CMD) && d_en) r = PH_DUMMY;
    else if (cur != PH_DATA && x_en) r = PH_DATA;
    return r;
  endfunction

  // map a raw 16-bit value onto the active lanes, optionally mirrored
  function automatic logic [15:0] lane_out(input logic [15:0] raw,
                                           input logic wide, input logic rev);
    logic [15:0] r;
    if (wide) r = rev ? rev16(raw) : raw;
    else      r = {8'h00, (rev ? rev8(raw[7:0]) : raw[7:0])};
    return r;
  endfunction

endpackage

// File: rtl/pbus_phase_ctrl.sv
module pbus_phase_ctrl
  import pbus_pkg::*;
#(
  parameter int DUMMY_CW = 8,
  parameter int DATA_CW  = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                kill,
  input  logic                arm,
  input  logic                tick,
  input  logic                cmd_en,
  input  logic                cmd_two,
  input  logic                dummy_en,
  input  logic [DUMMY_CW-1:0] dummy_m1,
  input  logic                data_en,
  input  logic [DATA_CW-1:0]  data_m1,
  input  logic                stream,
  input  logic                wide,
  input  logic                in_valid,
  output phase_e              phase_q,
  output logic                busy_q,
  output logic                emit,
  output logic                take,
  output logic                fin,
  output phase_e              nph,
  output logic                nhi
);
  localparam int CNT_W = (DUMMY_CW > DATA_CW) ? DUMMY_CW : DATA_CW;

  logic [CNT_W-1:0] cnt_q, ncnt;
  logic             hi_q;
  phase_e           cand;
  logic             fresh, need;

  always_comb begin
    emit  = 1'b0;
    take  = 1'b0;
    fin   = 1'b0;
    nph   = phase_q;
    nhi   = 1'b0;
    ncnt  = cnt_q;
    fresh = 1'b0;
    need  = 1'b0;
    cand  = PH_IDLE;
    if (busy_q && tick) begin
      if (phase_q == PH_IDLE) begin
        cand  = next_phase(PH_IDLE, cmd_en, dummy_en, data_en);
        fresh = 1'b1;
      end else if ((phase_q == PH_DATA && stream) || cnt_q != '0) begin
        cand = phase_q;
      end else begin
        cand  = next_phase(phase_q, cmd_en, dummy_en, data_en);
        fresh = 1'b1;
      end
      case (cand)
        PH_IDLE: fin = 1'b1;
        PH_CMD: begin
          emit = 1'b1;
          nph  = PH_CMD;
          nhi  = !fresh;
          ncnt = fresh ? CNT_W'(cmd_two) : cnt_q - 1'b1;
        end
        PH_DUMMY: begin
          emit = 1'b1;
          nph  = PH_DUMMY;
          ncnt = fresh ? CNT_W'(dummy_m1) : cnt_q - 1'b1;
        end
        default: begin
          need = wide || fresh || hi_q;
          if (need && !in_valid) begin
            fin = stream && !fresh;
          end else begin
            emit = 1'b1;
            take = need;
            nph  = PH_DATA;
            nhi  = !wide && !need;
            if (fresh)       ncnt = CNT_W'(data_m1);
            else if (!stream) ncnt = cnt_q - 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      busy_q  <= 1'b0;
      hi_q    <= 1'b0;
      cnt_q   <= '0;
    end else if (kill || fin) begin
      phase_q <= PH_IDLE;
      busy_q  <= 1'b0;
      hi_q    <= 1'b0;
      cnt_q   <= '0;
    end else if (arm) begin
      phase_q <= PH_IDLE;
      busy_q  <= 1'b1;
      hi_q    <= 1'b0;
      cnt_q   <= '0;
    end else if (emit) begin
      phase_q <= nph;
      hi_q    <= nhi;
      cnt_q   <= ncnt;
    end
  end
endmodule

// File: rtl/pbus_fmt.sv
module pbus_fmt
  import pbus_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        emit,
  input  logic        take,
  input  phase_e      nph,
  input  logic        nhi,
  input  logic [15:0] in_data,
  input  logic [31:0] cmd_word,
  input  logic        wide,
  input  logic        swap,
  input  logic        bitrev,
  input  logic        dc_idle,
  input  logic [2:0]  dc_inv,
  output logic [15:0] bus_data,
  output logic        bus_dc
);
  logic [15:0] word_q, src, raw;
  logic        inv;

  assign src = take ? in_data : word_q;

  always_comb begin
    raw = '0;
    inv = 1'b0;
    case (nph)
      PH_CMD: begin
        raw = nhi ? cmd_word[31:16] : cmd_word[15:0];
        inv = dc_inv[0];
      end
      PH_DUMMY: inv = dc_inv[1];
      PH_DATA: begin
        inv = dc_inv[2];
        if (wide) raw = swap ? {src[7:0], src[15:8]} : src;
        else      raw = {8'h00, ((nhi ^ swap) ? src[15:8] : src[7:0])};
      end
      default: raw = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      bus_data <= '0;
      bus_dc   <= 1'b0;
    end else if (clear) begin
      bus_data <= '0;
      bus_dc   <= dc_idle;
    end else if (emit) begin
      if (take) word_q <= in_data;
      bus_data <= lane_out(raw, wide, bitrev);
      bus_dc   <= dc_idle ^ inv;
    end
  end
endmodule

// File: rtl/pbus_irq.sv
module pbus_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wipe,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] status,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      status[i] <= 1'b0;
      else if (wipe)   status[i] <= 1'b0;
      else if (set[i]) status[i] <= 1'b1;
      else if (clr[i]) status[i] <= 1'b0;
    end
  end

  assign irq = |(status & en);
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int DUMMY_CW = 8,
  parameter int DATA_CW  = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic                soft_rst,
  input  logic                tick,
  input  logic                cfg_cmd_en,
  input  logic                cfg_cmd_two,
  input  logic                cfg_dummy_en,
  input  logic [DUMMY_CW-1:0] cfg_dummy_m1,
  input  logic                cfg_data_en,
  input  logic [DATA_CW-1:0]  cfg_data_m1,
  input  logic                cfg_stream,
  input  logic                cfg_wide,
  input  logic                cfg_swap,
  input  logic                cfg_bitrev,
  input  logic                cfg_dc_idle,
  input  logic                cfg_dc_cmd_inv,
  input  logic                cfg_dc_dummy_inv,
  input  logic                cfg_dc_data_inv,
  input  logic [31:0]         cfg_cmd_word,
  input  logic [15:0]         in_data,
  input  logic                in_valid,
  output logic                in_ready,
  output logic [15:0]         bus_data,
  output logic                bus_dc,
  output logic                busy,
  input  logic                vsync_evt,
  input  logic [1:0]          irq_en,
  input  logic [1:0]          irq_clr,
  output logic [1:0]          irq_status,
  output logic                irq
);
  logic                go_q;
  logic                l_cmd_en, l_cmd_two, l_dummy_en, l_data_en, l_stream;
  logic                l_wide, l_swap, l_bitrev, l_dc_idle;
  logic [2:0]          l_dc_inv;
  logic [DUMMY_CW-1:0] l_dummy_m1;
  logic [DATA_CW-1:0]  l_data_m1;
  logic [31:0]         l_cmd_word;

  // named internal events
  logic   arm, kill, emit, take, done_evt, nhi;
  phase_e phase_q, nph;

  assign arm  = go && !go_q && !busy && !soft_rst;
  assign kill = soft_rst || (busy && !go);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q       <= 1'b0;
      l_cmd_en   <= 1'b0;
      l_cmd_two  <= 1'b0;
      l_dummy_en <= 1'b0;
      l_data_en  <= 1'b0;
      l_stream   <= 1'b0;
      l_wide     <= 1'b0;
      l_swap     <= 1'b0;
      l_bitrev   <= 1'b0;
      l_dc_idle  <= 1'b0;
      l_dc_inv   <= '0;
      l_dummy_m1 <= '0;
      l_data_m1  <= '0;
      l_cmd_word <= '0;
    end else begin
      go_q <= go;
      if (arm) begin
        l_cmd_en   <= cfg_cmd_en;
        l_cmd_two  <= cfg_cmd_two;
        l_dummy_en <= cfg_dummy_en;
        l_data_en  <= cfg_data_en;
        l_stream   <= cfg_stream;
        l_wide     <= cfg_wide;
        l_swap     <= cfg_swap;
        l_bitrev   <= cfg_bitrev;
        l_dc_idle  <= cfg_dc_idle;
        l_dc_inv   <= {cfg_dc_data_inv, cfg_dc_dummy_inv, cfg_dc_cmd_inv};
        l_dummy_m1 <= cfg_dummy_m1;
        l_data_m1  <= cfg_data_m1;
        l_cmd_word <= cfg_cmd_word;
      end
    end
  end

  pbus_phase_ctrl #(.DUMMY_CW(DUMMY_CW), .DATA_CW(DATA_CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .kill(kill), .arm(arm), .tick(tick),
    .cmd_en(l_cmd_en), .cmd_two(l_cmd_two), .dummy_en(l_dummy_en),
    .dummy_m1(l_dummy_m1), .data_en(l_data_en), .data_m1(l_data_m1),
    .stream(l_stream), .wide(l_wide), .in_valid(in_valid),
    .phase_q(phase_q), .busy_q(busy), .emit(emit), .take(take),
    .fin(done_evt), .nph(nph), .nhi(nhi)
  );

  assign in_ready = take;

  pbus_fmt u_fmt (
    .clk(clk), .rst_n(rst_n), .clear(kill || done_evt), .emit(emit),
    .take(take), .nph(nph), .nhi(nhi), .in_data(in_data),
    .cmd_word(l_cmd_word), .wide(l_wide), .swap(l_swap),
    .bitrev(l_bitrev), .dc_idle(l_dc_idle), .dc_inv(l_dc_inv),
    .bus_data(bus_data), .bus_dc(bus_dc)
  );

  pbus_irq #(.N(2)) u_irq (
    .clk(clk), .rst_n(rst_n), .wipe(soft_rst),
    .set({vsync_evt, done_evt}), .clr(irq_clr), .en(irq_en),
    .status(irq_status), .irq(irq)
  );
endmodule

// File: rtl/pbus_seq_chk.sv
module pbus_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        go,
  input logic        soft_rst,
  input logic        tick,
  input logic        busy,
  input logic        in_ready,
  input logic        in_valid,
  input logic        done_evt,
  input logic [1:0]  phase,
  input logic [15:0] bus_data,
  input logic        bus_dc,
  input logic        dc_idle_lat,
  input logic [1:0]  irq_status,
  input logic [1:0]  irq_clr
);
  // dummy phase never steps back to command
  p_order_dummy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd2 |=> phase != 2'd1);

  // data phase only stays or leaves to idle
  p_order_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd3 |=> (phase == 2'd3 || phase == 2'd0));

  p_idle_dc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> bus_dc == dc_idle_lat);

  p_ready_qual_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (tick && busy && in_valid));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && go && !soft_rst) |=> ($stable(bus_data) && $stable(bus_dc)));

  p_done_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status[0] && !irq_clr[0] && !soft_rst) |=> irq_status[0]);

  p_wipe_r13: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (irq_status == 2'b00 && !busy));

  p_end_r14: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!busy && bus_data == 16'h0000 && irq_status[0]));
endmodule

bind pbus_seq pbus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .soft_rst(soft_rst), .tick(tick),
  .busy(busy), .in_ready(in_ready), .in_valid(in_valid),
  .done_evt(done_evt), .phase(phase_q), .bus_data(bus_data),
  .bus_dc(bus_dc), .dc_idle_lat(l_dc_idle), .irq_status(irq_status),
  .irq_clr(irq_clr)
);

// File: tb/pbus_seq_tb.sv
module pbus_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic go = 0, soft_rst = 0, tick = 0;
  logic cmd_en = 0, cmd_two = 0, dummy_en = 0, data_en = 0, stream = 0;
  logic wide = 0, swap = 0, bitrev = 0, dc_idle = 0;
  logic dc_ci = 0, dc_di = 0, dc_xi = 0;
  logic [7:0]  dummy_m1 = 0;
  logic [12:0] data_m1 = 0;
  logic [31:0] cmd_word = 0;
  logic [15:0] in_data;
  logic        in_valid, in_ready;
  logic [15:0] bus_data;
  logic        bus_dc, busy, irq;
  logic        vsync_evt = 0;
  logic [1:0]  irq_en = 0, irq_clr = 0, irq_status;

  int n_tests = 0, n_fail = 0;
  logic [15:0] words [8];
  int nwords = 0, idx;
  logic feed_rst = 0;

  always #2 clk = ~clk;

  pbus_seq u_dut (
    .clk(clk), .rst_n(rst_n), .go(go), .soft_rst(soft_rst), .tick(tick),
    .cfg_cmd_en(cmd_en), .cfg_cmd_two(cmd_two), .cfg_dummy_en(dummy_en),
    .cfg_dummy_m1(dummy_m1), .cfg_data_en(data_en), .cfg_data_m1(data_m1),
    .cfg_stream(stream), .cfg_wide(wide), .cfg_swap(swap),
    .cfg_bitrev(bitrev), .cfg_dc_idle(dc_idle), .cfg_dc_cmd_inv(dc_ci),
    .cfg_dc_dummy_inv(dc_di), .cfg_dc_data_inv(dc_xi),
    .cfg_cmd_word(cmd_word), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .bus_data(bus_data), .bus_dc(bus_dc),
    .busy(busy), .vsync_evt(vsync_evt), .irq_en(irq_en),
    .irq_clr(irq_clr), .irq_status(irq_status), .irq(irq)
  );

  always @(posedge clk) begin
    if (feed_rst) idx <= 0;
    else if (in_ready) idx <= idx + 1;
  end
  assign in_valid = (idx < nwords);
  assign in_data  = words[idx[2:0]];

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_clear();
    cmd_en = 0; cmd_two = 0; dummy_en = 0; data_en = 0; stream = 0;
    wide = 0; swap = 0; bitrev = 0; dc_idle = 0; dc_ci = 0; dc_di = 0;
    dc_xi = 0; dummy_m1 = 0; data_m1 = 0; cmd_word = 0;
  endtask

  task automatic feed(input int n);
    @(negedge clk) feed_rst = 1; nwords = n;
    @(negedge clk) feed_rst = 0;
  endtask

  task automatic begin_run();
    @(negedge clk) go = 1;
    @(negedge clk);
    chk({31'd0, busy}, 1, "R9 busy after go");
  endtask

  task automatic end_run();
    @(negedge clk) go = 0;
    @(negedge clk);
  endtask

  task automatic step();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
  endtask

  task automatic step_chk(input logic [15:0] d, input logic dc, input logic b, input string tag);
    step();
    chk({16'd0, bus_data}, {16'd0, d}, {tag, " data"});
    chk({31'd0, bus_dc}, {31'd0, dc}, {tag, " dc"});
    chk({31'd0, busy}, {31'd0, b}, {tag, " busy"});
  endtask

  task automatic clr_status();
    @(negedge clk) irq_clr = 2'b11;
    @(negedge clk) irq_clr = 2'b00;
  endtask

  task automatic t_reset();
    chk({16'd0, bus_data}, 0, "R14 reset bus");
    chk({31'd0, busy}, 0, "R14 reset busy");
    chk({30'd0, irq_status}, 0, "R12 reset status");
    chk({31'd0, irq}, 0, "R12 reset irq");
  endtask

  // 16-bit full sequence with per-phase DC levels
  task automatic t_full16();
    cfg_clear();
    cmd_en = 1; cmd_two = 1; dummy_en = 1; dummy_m1 = 1; data_en = 1; data_m1 = 2;
    wide = 1; dc_idle = 1; dc_ci = 1; dc_di = 0; dc_xi = 1;
    cmd_word = 32'hBEEF_1234;
    words[0] = 16'h1111; words[1] = 16'h2222; words[2] = 16'h3333;
    feed(3);
    clr_status();
    begin_run();
    step_chk(16'h1234, 0, 1, "R2 cmd lo");
    step_chk(16'hBEEF, 0, 1, "R2 cmd hi");
    step_chk(16'h0000, 1, 1, "R3 dummy 1");
    step_chk(16'h0000, 1, 1, "R5 dummy 2");
    step_chk(16'h1111, 0, 1, "R7 data 1");
    step_chk(16'h2222, 0, 1, "R1 data 2");
    step_chk(16'h3333, 0, 1, "R3 data 3");
    step_chk(16'h0000, 1, 0, "R14 end");
    chk({31'd0, irq_status[0]}, 1, "R14 done set");
    end_run();
  endtask

  // 8-bit, one-cycle command, swapped byte pairs
  task automatic t_swap8();
    cfg_clear();
    cmd_en = 1; data_en = 1; data_m1 = 3; swap = 1; cmd_word = 32'h0000_AB5C;
    words[0] = 16'hA1B2; words[1] = 16'hC3D4;
    feed(2);
    begin_run();
    step_chk(16'h005C, 0, 1, "R2 cmd 8bit");
    step_chk(16'h00A1, 0, 1, "R6 swap b1");
    step_chk(16'h00B2, 0, 1, "R6 swap b0");
    step_chk(16'h00C3, 0, 1, "R6 swap b3");
    step_chk(16'h00D4, 0, 1, "R6 swap b2");
    step_chk(16'h0000, 0, 0, "R14 end 8bit");
    end_run();
  endtask

  task automatic t_swap16();
    cfg_clear();
    data_en = 1; wide = 1; swap = 1; words[0] = 16'hA1B2;
    feed(1);
    begin_run();
    step_chk(16'hB2A1, 0, 1, "R7 swap16");
    step_chk(16'h0000, 0, 0, "R7 end");
    end_run();
  endtask

  task automatic t_bitrev();
    cfg_clear();
    data_en = 1; wide = 1; bitrev = 1; words[0] = 16'h0001;
    feed(1);
    begin_run();
    step_chk(16'h8000, 0, 1, "R8 rev16");
    step_chk(16'h0000, 0, 0, "R8 end16");
    end_run();
    cfg_clear();
    cmd_en = 1; cmd_two = 1; bitrev = 1; cmd_word = 32'h000F_0003;
    begin_run();
    step_chk(16'h00C0, 0, 1, "R8 rev8 cmd lo");
    step_chk(16'h00F0, 0, 1, "R2 rev8 cmd hi");
    step_chk(16'h0000, 0, 0, "R8 end8");
    end_run();
  endtask

  task automatic t_stream();
    cfg_clear();
    data_en = 1; wide = 1; stream = 1; data_m1 = 0; dc_idle = 1;
    for (int i = 0; i < 5; i++) words[i] = 16'h0100 + 16'(i);
    feed(5);
    begin_run();
    for (int i = 0; i < 5; i++) step_chk(16'h0100 + 16'(i), 1, 1, "R4 stream word");
    step_chk(16'h0000, 1, 0, "R4 stream end");
    end_run();
  endtask

  task automatic t_stall();
    cfg_clear();
    data_en = 1; data_m1 = 1; words[0] = 16'h1234;
    feed(0);
    begin_run();
    @(negedge clk) tick = 1;
    #1 chk({31'd0, in_ready}, 0, "R11 no ready when empty");
    @(negedge clk) tick = 0;
    chk({31'd0, busy}, 1, "R11 stall busy");
    chk({16'd0, bus_data}, 0, "R11 stall hold");
    nwords = 1;
    step_chk(16'h0034, 0, 1, "R6 low first");
    step_chk(16'h0012, 0, 1, "R6 high second");
    step_chk(16'h0000, 0, 0, "R11 end");
    end_run();
  endtask

  task automatic t_abort();
    cfg_clear();
    cmd_en = 1; cmd_two = 1; dc_idle = 1; dc_ci = 1; cmd_word = 32'h5555_AAAA; wide = 1;
    clr_status();
    begin_run();
    step_chk(16'hAAAA, 0, 1, "R10 pre abort");
    @(negedge clk) go = 0;
    @(negedge clk);
    chk({31'd0, busy}, 0, "R10 abort busy");
    chk({16'd0, bus_data}, 0, "R10 abort bus");
    chk({31'd0, bus_dc}, 1, "R10 abort dc idle");
    chk({31'd0, irq_status[0]}, 0, "R10 no done");
  endtask

  task automatic t_latch();
    cfg_clear();
    data_en = 1; data_m1 = 1; wide = 1; dc_xi = 1;
    words[0] = 16'hCAFE; words[1] = 16'hF00D;
    feed(2);
    begin_run();
    wide = 0; dc_idle = 1; data_m1 = 0; swap = 1;
    step_chk(16'hCAFE, 1, 1, "R9 latched wide");
    step_chk(16'hF00D, 1, 1, "R9 latched len");
    step_chk(16'h0000, 0, 0, "R9 latched idle");
    end_run();
  endtask

  task automatic t_irq();
    cfg_clear();
    clr_status();
    begin_run();
    step_chk(16'h0000, 0, 0, "R1 no phases");
    chk({30'd0, irq_status}, 2'b01, "R12 done only");
    chk({31'd0, irq}, 0, "R12 masked");
    end_run();
    @(negedge clk) irq_en = 2'b01;
    #1 chk({31'd0, irq}, 1, "R12 enabled");
    @(negedge clk) vsync_evt = 1;
    @(negedge clk) vsync_evt = 0;
    chk({30'd0, irq_status}, 2'b11, "R12 vsync set");
    @(negedge clk) irq_clr = 2'b01;
    @(negedge clk) irq_clr = 2'b00;
    chk({30'd0, irq_status}, 2'b10, "R12 w1c");
    chk({31'd0, irq}, 0, "R12 cleared irq");
    @(negedge clk) irq_en = 2'b10;
    #1 chk({31'd0, irq}, 1, "R12 vsync irq");
    @(negedge clk) vsync_evt = 1; irq_clr = 2'b10;
    @(negedge clk) vsync_evt = 0; irq_clr = 2'b00;
    chk({30'd0, irq_status}, 2'b10, "R12 set wins");
    irq_en = 0;
  endtask

  task automatic t_soft();
    cfg_clear();
    cmd_en = 1; cmd_two = 1; wide = 1; cmd_word = 32'h0000_7777;
    begin_run();
    step_chk(16'h7777, 0, 1, "R13 pre");
    @(negedge clk) soft_rst = 1;
    @(negedge clk) soft_rst = 0;
    chk({31'd0, busy}, 0, "R13 abort");
    chk({30'd0, irq_status}, 0, "R13 wiped");
    end_run();
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    feed_rst = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk) feed_rst = 0;
    t_reset();
    t_full16();
    t_swap8();
    t_swap16();
    t_bitrev();
    t_stream();
    t_stall();
    t_abort();
    t_latch();
    t_irq();
    t_soft();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule